// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This block records the value of a free-running time counter at the moment a transmit or receive packet event occurs. It has two independent channels, one per direction. Each channel holds exactly one stamp. Once a stamp is taken, the channel is locked against further captures. It stays locked until software has read the low capture word and then the high capture word. A stamp read out this way therefore always belongs to the single packet that was pending when it was taken.

Software reaches the block through a small word-addressed register port. Reads are combinational and take their side effects at the clock edge of the read strobe. Each channel has a control word with an enable bit and a read-only valid bit. The receive control word also carries a class field. This field either accepts every receive event or only those whose packet class input matches it. A transmit capture can raise a sticky interrupt cause, gated by a mask bit. The logic outside the block decides which packets qualify for stamping and presents that decision on a select input next to each event strobe.

Top module: `pkt_stamp_capture`

## Requirements
- R1: After reset, every register reads zero and `tx_irq_o` is low.
- R2: When a channel is enabled and not valid, an event strobe with its select input high captures `time_i` of that clock edge into the channel's capture words (low word = bits 31:0, high word = bits 63:32). The valid flag is set in the same edge.
- R3: While a channel is valid, further events on it leave the capture words and valid flag unchanged.
- R4: A read of the low capture word (transmit address 2, receive address 4), followed later by a read of the high word (address 3, receive address 5), clears the channel's valid flag. Other channel reads may come between the two.
- R5: A read of the high capture word without an earlier low read since the capture does not release the lock.
- R6: Writing 0 to a channel's enable bit (bit 0 of control address 0 for transmit, address 1 for receive) clears its valid flag. The valid flag is read back at bit 1 of the same word.
- R7: In the receive control word, bits 5:4 select the class. A value of 0 accepts any class. Any other value accepts only events whose `rx_class_i` equals that value.
- R8: A transmit capture sets the interrupt cause (bit 0 of address 7) only if the mask bit (bit 0 of address 6) is set. The cause drives `tx_irq_o`. Writing 1 to bit 0 of address 7 clears the cause.
- R9: Events with the select input low, or on a disabled channel, capture nothing.
- R10: The transmit and receive channels capture and release independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 64 | Current time counter value |
| tx_evt_i | input | 1 | Transmit event strobe |
| tx_sel_i | input | 1 | Transmit packet is selected for stamping |
| rx_evt_i | input | 1 | Receive event strobe |
| rx_sel_i | input | 1 | Receive packet is selected for stamping |
| rx_class_i | input | 2 | Class of the receive packet |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| tx_irq_o | output | 1 | Transmit stamp interrupt cause |

## Verification
Directed sequences cover the key lock cases:
- capture then release by a low-then-high read;
- a high read on its own, which must leave the lock in place;
- a second event while locked, which must leave the first stamp unchanged;
- disabling a locked channel.

The time counter starts just below a 32-bit carry, so a wrong word split or a stale capture shows up in the high word.

Events are also checked with the select input low, with matching and non-matching receive classes, and with the interrupt mask both set and clear.

A seeded random mix then interleaves events on both channels with reads, in any order, of every address and occasional control writes. This mix separates correct per-channel lock bookkeeping from logic that shares state between the channels, or that releases on any high read.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;
    localparam int CLASS_W = 2;
    localparam int N_CHAN  = 2;
    localparam int CH_TX   = 0;
    localparam int CH_RX   = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_TX_CTRL  = 3'd0,
        A_RX_CTRL  = 3'd1,
        A_TX_LO    = 3'd2,
        A_TX_HI    = 3'd3,
        A_RX_LO    = 3'd4,
        A_RX_HI    = 3'd5,
        A_IRQ_MASK = 3'd6,
        A_IRQ_CAUSE= 3'd7
    } reg_addr_e;

    localparam int B_EN      = 0;
    localparam int B_VALID   = 1;
    localparam int B_CLS_LO  = 4;
endpackage

// File: rtl/stamp_chan.sv
module stamp_chan #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              evt_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    output logic              valid_o,
    output logic [TIME_W-1:0] cap_o
);
    typedef struct packed {
        logic              valid;
        logic              lo_seen;
        logic [TIME_W-1:0] cap;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.valid   = 1'b0;
            st_d.lo_seen = 1'b0;
        end else if (st_q.valid) begin
            if (rd_lo_i) begin
                st_d.lo_seen = 1'b1;
            end else if (rd_hi_i && st_q.lo_seen) begin
                st_d.valid   = 1'b0;
                st_d.lo_seen = 1'b0;
            end
        end else if (evt_i) begin
            st_d.valid   = 1'b1;
            st_d.lo_seen = 1'b0;
            st_d.cap     = time_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign cap_o   = st_q.cap;

    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && evt_i && !valid_o) |=> (valid_o && cap_o == $past(time_i)));

    a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> $stable(cap_o));

    a_r5_hi_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && en_i && rd_hi_i && !st_q.lo_seen) |=> valid_o);

    a_r6_disable: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !valid_o);
endmodule

// File: rtl/pkt_stamp_capture.sv
module pkt_stamp_capture
    import stamp_pkg::*;
#(
    parameter int TIME_W = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  time_i,
    input  logic               tx_evt_i,
    input  logic               tx_sel_i,
    input  logic               rx_evt_i,
    input  logic               rx_sel_i,
    input  logic [CLASS_W-1:0] rx_class_i,
    input  logic               reg_wr_i,
    input  logic               reg_rd_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               tx_irq_o
);
    localparam int HALF_W = TIME_W / 2;

    typedef struct packed {
        logic [N_CHAN-1:0]  en;
        logic [CLASS_W-1:0] cls;
        logic               mask;
        logic               cause;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic [N_CHAN-1:0] ch_evt, ch_rd_lo, ch_rd_hi, ch_valid;
    logic [TIME_W-1:0] ch_cap [N_CHAN];
    logic              rx_class_ok;
    logic              tx_capture;

    assign rx_class_ok = (ctl_q.cls == '0) || (ctl_q.cls == rx_class_i);
    assign ch_evt[CH_TX] = tx_evt_i && tx_sel_i;
    assign ch_evt[CH_RX] = rx_evt_i && rx_sel_i && rx_class_ok;

    assign ch_rd_lo[CH_TX] = reg_rd_i && (reg_addr_i == A_TX_LO);
    assign ch_rd_hi[CH_TX] = reg_rd_i && (reg_addr_i == A_TX_HI);
    assign ch_rd_lo[CH_RX] = reg_rd_i && (reg_addr_i == A_RX_LO);
    assign ch_rd_hi[CH_RX] = reg_rd_i && (reg_addr_i == A_RX_HI);

    for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
        stamp_chan #(.TIME_W(TIME_W)) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (ctl_q.en[g]),
            .evt_i   (ch_evt[g]),
            .time_i  (time_i),
            .rd_lo_i (ch_rd_lo[g]),
            .rd_hi_i (ch_rd_hi[g]),
            .valid_o (ch_valid[g]),
            .cap_o   (ch_cap[g])
        );
    end

    assign tx_capture = ctl_q.en[CH_TX] && !ch_valid[CH_TX] && ch_evt[CH_TX];

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr_i) begin
            case (reg_addr_i)
                A_TX_CTRL:   ctl_d.en[CH_TX] = reg_wdata_i[B_EN];
                A_RX_CTRL: begin
                    ctl_d.en[CH_RX] = reg_wdata_i[B_EN];
                    ctl_d.cls       = reg_wdata_i[B_CLS_LO +: CLASS_W];
                end
                A_IRQ_MASK:  ctl_d.mask = reg_wdata_i[0];
                A_IRQ_CAUSE: if (reg_wdata_i[0]) ctl_d.cause = 1'b0;
                default: ;
            endcase
        end
        if (tx_capture && ctl_q.mask) ctl_d.cause = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_TX_CTRL: begin
                reg_rdata_o[B_EN]    = ctl_q.en[CH_TX];
                reg_rdata_o[B_VALID] = ch_valid[CH_TX];
            end
            A_RX_CTRL: begin
                reg_rdata_o[B_EN]    = ctl_q.en[CH_RX];
                reg_rdata_o[B_VALID] = ch_valid[CH_RX];
                reg_rdata_o[B_CLS_LO +: CLASS_W] = ctl_q.cls;
            end
            A_TX_LO:     reg_rdata_o = ch_cap[CH_TX][HALF_W-1:0];
            A_TX_HI:     reg_rdata_o = ch_cap[CH_TX][TIME_W-1:HALF_W];
            A_RX_LO:     reg_rdata_o = ch_cap[CH_RX][HALF_W-1:0];
            A_RX_HI:     reg_rdata_o = ch_cap[CH_RX][TIME_W-1:HALF_W];
            A_IRQ_MASK:  reg_rdata_o[0] = ctl_q.mask;
            A_IRQ_CAUSE: reg_rdata_o[0] = ctl_q.cause;
            default: ;
        endcase
    end

    assign tx_irq_o = ctl_q.cause;

    a_r7_class_block: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt_i && rx_sel_i && !ch_valid[CH_RX] && ctl_q.cls != '0
         && ctl_q.cls != rx_class_i) |=> !ch_valid[CH_RX]);

    a_r8_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ch_valid[CH_TX]) && $past(ctl_q.mask)) |-> tx_irq_o);

    a_r8_cause_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ch_valid[CH_TX]) && !$past(ctl_q.mask) && !$past(tx_irq_o)) |-> !tx_irq_o);

    a_r9_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_valid[CH_TX] && !tx_sel_i) |=> !ch_valid[CH_TX]);
endmodule

// File: tb/test_pkt_stamp_capture.sv
module test_pkt_stamp_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_r = 64'h0000_0001_FFFF_FFF0;
    logic        tx_evt = 0, tx_sel = 0, rx_evt = 0, rx_sel = 0;
    logic [1:0]  rx_class = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        tx_irq;

    int checks = 0;
    int fails  = 0;

    // bench model
    bit          m_en [2];
    bit          m_valid [2];
    bit          m_lo [2];
    logic [63:0] m_cap [2];
    logic [1:0]  m_cls;
    bit          m_mask, m_cause;

    always #2.5 clk = ~clk;
    always @(posedge clk) time_r <= time_r + 64'd1;

    pkt_stamp_capture i_pkt_stamp_capture (
        .clk(clk), .rst_n(rst_n), .time_i(time_r),
        .tx_evt_i(tx_evt), .tx_sel_i(tx_sel),
        .rx_evt_i(rx_evt), .rx_sel_i(rx_sel), .rx_class_i(rx_class),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .tx_irq_o(tx_irq)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [2:0] a);
        logic [31:0] v = '0;
        case (a)
            3'd0: begin v[0] = m_en[0]; v[1] = m_valid[0]; end
            3'd1: begin v[0] = m_en[1]; v[1] = m_valid[1]; v[5:4] = m_cls; end
            3'd2: v = m_cap[0][31:0];
            3'd3: v = m_cap[0][63:32];
            3'd4: v = m_cap[1][31:0];
            3'd5: v = m_cap[1][63:32];
            3'd6: v[0] = m_mask;
            default: v[0] = m_cause;
        endcase
        return v;
    endfunction

    task automatic rd(logic [2:0] a, string req);
        int ch;
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 check(req, reg_rdata, exp_rd(a));
        @(negedge clk);
        reg_rd = 0;
        ch = (a == 3'd2 || a == 3'd3) ? 0 : 1;
        if (a >= 3'd2 && a <= 3'd5 && m_en[ch] && m_valid[ch]) begin
            if (a == 3'd2 || a == 3'd4) m_lo[ch] = 1;
            else if (m_lo[ch]) begin m_valid[ch] = 0; m_lo[ch] = 0; end
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        case (a)
            3'd0: m_en[0] = d[0];
            3'd1: begin m_en[1] = d[0]; m_cls = d[5:4]; end
            3'd6: m_mask = d[0];
            3'd7: if (d[0]) m_cause = 0;
            default: ;
        endcase
        for (int c = 0; c < 2; c++) if (!m_en[c]) begin m_valid[c] = 0; m_lo[c] = 0; end
    endtask

    task automatic evt(int ch, bit sel, logic [1:0] cls);
        @(negedge clk);
        if (ch == 0) begin tx_evt = 1; tx_sel = sel; end
        else begin rx_evt = 1; rx_sel = sel; rx_class = cls; end
        if (m_en[ch] && sel && !m_valid[ch] && (ch == 0 || m_cls == 0 || m_cls == cls)) begin
            m_valid[ch] = 1; m_lo[ch] = 0; m_cap[ch] = time_r;
            if (ch == 0 && m_mask) m_cause = 1;
        end
        @(negedge clk);
        tx_evt = 0; tx_sel = 0; rx_evt = 0; rx_sel = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] first;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset reg");
        #1 check("R1 irq low", tx_irq, 0);

        // R9 disabled channel ignores events
        evt(0, 1, 0);
        rd(3'd0, "R9 disabled tx no capture");
        wr(3'd0, 1); wr(3'd6, 1);
        evt(0, 0, 0);
        rd(3'd0, "R9 unselected no capture");

        // R2 capture, R8 cause with mask
        evt(0, 1, 0);
        first = m_cap[0];
        rd(3'd0, "R2 tx valid set");
        #1 check("R8 irq raised", tx_irq, 1);
        // R3 second event ignored
        evt(0, 1, 0);
        check("R3 model holds first stamp", m_cap[0], first);
        rd(3'd3, "R5 hi alone keeps lock");
        rd(3'd0, "R5 still valid");
        rd(3'd2, "R2 low word");
        rd(3'd5, "R10 rx untouched by tx read");
        rd(3'd3, "R4 high word releases");
        rd(3'd0, "R4 valid cleared");
        wr(3'd7, 1);
        #1 check("R8 w1c clear", tx_irq, 0);

        // R8 masked: no cause
        wr(3'd6, 0);
        evt(0, 1, 0);
        #1 check("R8 masked no irq", tx_irq, 0);
        // R6 disable clears valid
        wr(3'd0, 0);
        rd(3'd0, "R6 disable clears valid");
        wr(3'd0, 1);

        // R7 class filter
        wr(3'd1, 32'h21);
        evt(1, 1, 2'd1);
        rd(3'd1, "R7 class mismatch blocked");
        evt(1, 1, 2'd2);
        rd(3'd1, "R7 class match captured");
        rd(3'd4, "R7 rx low"); rd(3'd5, "R7 rx high");
        wr(3'd1, 32'h01);
        evt(1, 1, 2'd3);
        rd(3'd1, "R7 all-class captured");
        rd(3'd5, "R10 rx hi");

        // random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned r = $urandom % 10;
            case (r)
                0, 1: evt(0, ($urandom % 4) != 0, 0);
                2, 3: evt(1, ($urandom % 4) != 0, 2'($urandom));
                4, 5: rd(3'($urandom), "R4 random read");
                6:    rd(($urandom % 2) ? 3'd2 : 3'd4, "R4 random low");
                7:    rd(($urandom % 2) ? 3'd3 : 3'd5, "R5 random high");
                8:    wr(3'(($urandom % 2) ? 0 : 1),
                         {26'd0, 2'($urandom), 3'd0, ($urandom % 5) != 0});
                default: wr(3'(6 + $urandom % 2), 32'($urandom % 2));
            endcase
            #1 check("R8 irq random", tx_irq, m_cause);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule